// File: doc/BRIEF.md
# Time-Multiplexed Multi-Band Biquad Equalizer

This block applies a chain of second-order recursive filter sections, one per equalizer band, to a stream of audio samples using a single shared arithmetic core. When a sample is accepted, the block walks through the bands in ascending order. For each band it reads the band's four coefficients and its two delay terms from dedicated memories. It then computes the section output, writes the updated delay terms back, and passes the result on as the input of the next band. Every band takes two cycles, so a 27-band chain needs 54 cycles per sample.

Coefficients are loaded through a simple write port carrying a band index and one 128-bit word that holds all four coefficients of that band. The port may be used at any time. A write that arrives while a pass is running is parked and applied only after the pass ends, so that a sample never sees a mix of old and new settings. All arithmetic uses signed fixed-point integers. The delay terms are kept much wider than the sample so that large internal node values in low-frequency bands do not wrap.

Top module: `tdm_biquad_eq`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and all coefficients and delay terms are zero, so each sample comes out unchanged.
- R2: `out_valid` rises exactly 54 rising edges after the edge at which a sample is accepted (`in_valid` and `in_ready` both high), and it stays high for one cycle only.
- R3: `in_ready` is low from the acceptance edge until the pass ends. `in_valid` seen while `in_ready` is low is ignored: it produces no extra output and does not change the result.
- R4: Each band computes y = x + s1, s1' = ((b1*x − a1*y) >>> 30) + s2 and s2' = (b2*x − a2*y) >>> 30. Coefficients are signed Q2.30, and samples and delay terms are signed values with 23 fraction bits.
- R5: Bands run in the order 0 to 26. The output of band k is the input of band k+1, and the output of band 26 is the sample result.
- R6: Each band keeps its own delay terms from one sample to the next.
- R7: The result is saturated to the 24-bit signed range, 0x7FFFFF to 0x800000.
- R8: A coefficient write made while idle is used by the next sample. In `cfg_coef`, b1 is in bits [127:96], b2 in [95:64], a1 in [63:32] and a2 in [31:0].
- R9: A coefficient write made during a pass does not affect that pass. It takes effect from the next sample on.
- R10: Writes to band indices 27 to 29 are stored but do not influence the output. Writes to indices 30 and 31 are discarded.
- R11: Values between bands may exceed the sample range without being clipped. Only the final result is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | High while the block can accept a sample |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | 24 | Signed, saturated result |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_band | input | 5 | Band index of the write |
| cfg_coef | input | 128 | Packed coefficients {b1, b2, a1, a2} |

## Verification
Pass-through samples on a reset block expose the latency and the reset state. A single programmed band, driven over several samples, separates correct recursion and per-band memory from a core that forgets or shares state. Two active bands far apart in the chain show whether the cascade order and the hand-over between bands are right. Full-scale sample pairs separate final saturation from internal clipping. Writes issued mid-pass, and writes to unused band slots, show whether coefficient changes are isolated correctly.

// File: rtl/eq_pkg.sv
package eq_pkg;
    localparam int COEF_W    = 32;
    localparam int COEF_FRAC = 30;

    typedef struct packed {
        logic signed [COEF_W-1:0] b1;
        logic signed [COEF_W-1:0] b2;
        logic signed [COEF_W-1:0] a1;
        logic signed [COEF_W-1:0] a2;
    } coef_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_CALC  = 2'd2
    } seq_st_t;
endpackage

// File: rtl/eq_sequencer.sv
module eq_sequencer
    import eq_pkg::*;
#(
    parameter int NBANDS = 27,
    parameter int BW     = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          calc,
    output logic          last,
    output logic [BW-1:0] band
);
    localparam logic [BW-1:0] LASTB = BW'(NBANDS - 1);

    seq_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            band <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: if (start) begin
                    st   <= SQ_FETCH;
                    band <= '0;
                end
                SQ_FETCH: st <= SQ_CALC;
                SQ_CALC: begin
                    if (band == LASTB) begin
                        st <= SQ_IDLE;
                    end else begin
                        st   <= SQ_FETCH;
                        band <= band + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (st != SQ_IDLE);
    assign calc = (st == SQ_CALC);
    assign last = calc && (band == LASTB);

    // R2: every band but the last is followed by a fetch of the next one
    a_r2_band_step: assert property (@(posedge clk) disable iff (rst)
        (calc && !last) |=> (st == SQ_FETCH && band == $past(band) + 1'b1));
    // R2: the pass ends right after the last band
    a_r2_last_ends: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
endmodule

// File: rtl/eq_coef_store.sv
module eq_coef_store
    import eq_pkg::*;
#(
    parameter int CDEPTH = 30,
    parameter int BW     = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [BW-1:0] wr_addr,
    input  coef_t         wr_data,
    input  logic [BW-1:0] rd_addr,
    output coef_t         rd_q
);
    coef_t mem [CDEPTH];
    logic  in_range;

    assign in_range = ({1'b0, wr_addr} < (BW + 1)'(CDEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CDEPTH; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (we && in_range) mem[wr_addr] <= wr_data;
            rd_q <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/eq_state_store.sv
module eq_state_store #(
    parameter int NBANDS = 27,
    parameter int BW     = 5,
    parameter int STW    = 48
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BW-1:0]         rd_addr,
    output logic signed [STW-1:0] s1_q,
    output logic signed [STW-1:0] s2_q,
    input  logic                  we,
    input  logic [BW-1:0]         wr_addr,
    input  logic signed [STW-1:0] s1_d,
    input  logic signed [STW-1:0] s2_d
);
    logic signed [STW-1:0] m1 [NBANDS];
    logic signed [STW-1:0] m2 [NBANDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBANDS; i++) begin
                m1[i] <= '0;
                m2[i] <= '0;
            end
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            if (we) begin
                m1[wr_addr] <= s1_d;
                m2[wr_addr] <= s2_d;
            end
            s1_q <= m1[rd_addr];
            s2_q <= m2[rd_addr];
        end
    end

    // R6: writes only ever target an existing band slot
    a_r6_write_in_range: assert property (@(posedge clk) disable iff (rst)
        we |-> ({1'b0, wr_addr} < (BW + 1)'(NBANDS)));
endmodule

// File: rtl/eq_biquad_alu.sv
module eq_biquad_alu
    import eq_pkg::*;
#(
    parameter int STW = 48
) (
    input  logic signed [STW-1:0] x,
    input  logic signed [STW-1:0] s1,
    input  logic signed [STW-1:0] s2,
    input  coef_t                 c,
    output logic signed [STW-1:0] y,
    output logic signed [STW-1:0] s1_n,
    output logic signed [STW-1:0] s2_n
);
    localparam int PW = STW + COEF_W + 1;

    logic signed [PW-1:0] xw, yw, acc1, acc2, sh1, sh2;

    always_comb begin
        y    = x + s1;
        xw   = PW'(x);
        yw   = PW'(y);
        acc1 = PW'(c.b1) * xw - PW'(c.a1) * yw;
        acc2 = PW'(c.b2) * xw - PW'(c.a2) * yw;
        sh1  = acc1 >>> COEF_FRAC;
        sh2  = acc2 >>> COEF_FRAC;
        s1_n = STW'(sh1) + s2;
        s2_n = STW'(sh2);
    end
endmodule

// File: rtl/tdm_biquad_eq.sv
module tdm_biquad_eq
    import eq_pkg::*;
#(
    parameter int NBANDS = 27,
    parameter int CDEPTH = 30,
    parameter int SW     = 24,
    parameter int STW    = 48,
    localparam int BW    = $clog2(CDEPTH),
    localparam int CW    = 4 * COEF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_sample,
    output logic          out_valid,
    output logic [SW-1:0] out_sample,
    input  logic          cfg_we,
    input  logic [BW-1:0] cfg_band,
    input  logic [CW-1:0] cfg_coef
);
    localparam logic signed [STW-1:0] YMAX = STW'((64'sd1 <<< (SW - 1)) - 64'sd1);
    localparam logic signed [STW-1:0] YMIN = STW'(-(64'sd1 <<< (SW - 1)));

    logic          busy, calc, last, accept;
    logic [BW-1:0] band;

    logic                  cw_en;
    logic [BW-1:0]         cw_band;
    coef_t                 cw_data;
    logic                  pend_v;
    logic [BW-1:0]         pend_band;
    coef_t                 pend_coef;

    coef_t                 c_q;
    logic signed [STW-1:0] s1_q, s2_q, y, s1_n, s2_n, cur;

    assign in_ready = !busy;
    assign accept   = in_valid && !busy;

    eq_sequencer #(.NBANDS(NBANDS), .BW(BW)) u_seq (
        .clk(clk), .rst(rst), .start(accept),
        .busy(busy), .calc(calc), .last(last), .band(band)
    );

    // coefficient write path: parked while a pass runs
    always_comb begin
        cw_en   = 1'b0;
        cw_band = cfg_band;
        cw_data = coef_t'(cfg_coef);
        if (!busy && pend_v) begin
            cw_en   = 1'b1;
            cw_band = pend_band;
            cw_data = pend_coef;
        end else if (!busy && cfg_we) begin
            cw_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_band <= '0;
            pend_coef <= '0;
        end else if (cfg_we && (busy || pend_v)) begin
            pend_v    <= 1'b1;
            pend_band <= cfg_band;
            pend_coef <= coef_t'(cfg_coef);
        end else if (!busy && pend_v) begin
            pend_v <= 1'b0;
        end
    end

    eq_coef_store #(.CDEPTH(CDEPTH), .BW(BW)) u_coef (
        .clk(clk), .rst(rst), .we(cw_en), .wr_addr(cw_band), .wr_data(cw_data),
        .rd_addr(band), .rd_q(c_q)
    );

    eq_state_store #(.NBANDS(NBANDS), .BW(BW), .STW(STW)) u_state (
        .clk(clk), .rst(rst), .rd_addr(band), .s1_q(s1_q), .s2_q(s2_q),
        .we(calc), .wr_addr(band), .s1_d(s1_n), .s2_d(s2_n)
    );

    eq_biquad_alu #(.STW(STW)) u_alu (
        .x(cur), .s1(s1_q), .s2(s2_q), .c(c_q),
        .y(y), .s1_n(s1_n), .s2_n(s2_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            if (accept)    cur <= STW'($signed(in_sample));
            else if (calc) cur <= y;
            out_valid <= last;
            if (last) begin
                if (y > YMAX)      out_sample <= YMAX[SW-1:0];
                else if (y < YMIN) out_sample <= YMIN[SW-1:0];
                else               out_sample <= y[SW-1:0];
            end
        end
    end

    // R3: an accepted sample closes the input until the pass ends
    a_r3_accept_closes: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);
    // R2: the result strobe lasts a single cycle
    a_r2_out_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R2: the result strobe follows the last band directly
    a_r2_out_after_last: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(last));
    // R9: a parked write is released on the first idle cycle
    a_r9_pending_drains: assert property (@(posedge clk) disable iff (rst)
        (!busy && pend_v && !cfg_we) |=> !pend_v);
    // R9: a parked write survives until the pass is over
    a_r9_pending_held: assert property (@(posedge clk) disable iff (rst)
        (busy && pend_v) |=> pend_v);
endmodule

// File: tb/tdm_biquad_eq_test.sv
module tdm_biquad_eq_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [23:0]  in_sample = '0;
    logic         out_valid;
    logic [23:0]  out_sample;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_band = '0;
    logic [127:0] cfg_coef = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    logic [127:0]        mc  [30];
    logic signed [47:0]  ms1 [27];
    logic signed [47:0]  ms2 [27];

    localparam logic [31:0] ONE  = 32'h4000_0000;
    localparam logic [31:0] MONE = 32'hC000_0000;
    localparam logic [31:0] HALF = 32'h2000_0000;
    localparam logic [31:0] QTR  = 32'h1000_0000;
    localparam logic [31:0] MHLF = 32'hE000_0000;

    always #2.5 clk = ~clk;

    tdm_biquad_eq uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample),
        .cfg_we(cfg_we), .cfg_band(cfg_band), .cfg_coef(cfg_coef)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_run(input logic [23:0] xin);
        logic signed [47:0] v, y;
        logic signed [95:0] a1, a2;
        v = 48'($signed(xin));
        for (int b = 0; b < 27; b++) begin
            y  = v + ms1[b];
            a1 = (96'($signed(mc[b][127:96])) * 96'(v)
                - 96'($signed(mc[b][63:32])) * 96'(y)) >>> 30;
            a2 = (96'($signed(mc[b][95:64])) * 96'(v)
                - 96'($signed(mc[b][31:0])) * 96'(y)) >>> 30;
            ms1[b] = a1[47:0] + ms2[b];
            ms2[b] = a2[47:0];
            v = y;
        end
        if (v > 48'sh7F_FFFF) return 24'h7F_FFFF;
        if (v < -48'sh80_0000) return 24'h80_0000;
        return v[23:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; cfg_we = 1'b0;
        for (int i = 0; i < 30; i++) mc[i] = '0;
        for (int i = 0; i < 27; i++) begin ms1[i] = '0; ms2[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_coef(input logic [4:0] b, input logic [127:0] v);
        cfg_we = 1'b1; cfg_band = b; cfg_coef = v;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        if (b < 30) mc[b] = v;
    endtask

    // one sample through the chain; optional held in_valid and mid-pass write
    task automatic run_sample(input logic [23:0] x, input int hold, input bit mid,
                              input logic [4:0] mb, input logic [127:0] mcf,
                              input string req);
        logic [23:0] exp;
        int n;
        bit extra;
        exp = model_run(x);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_sample = x;
        @(posedge clk); @(negedge clk);
        check(in_ready == 1'b0, "R3 in_ready low in pass", 32'(in_ready), 0);
        in_sample = ~x;
        n = 0;
        while (!out_valid && n < 100) begin
            if (n >= hold) in_valid = 1'b0;
            if (mid && n == 20) begin
                cfg_we = 1'b1; cfg_band = mb; cfg_coef = mcf;
            end else cfg_we = 1'b0;
            @(posedge clk); @(negedge clk);
            n++;
        end
        in_valid = 1'b0; cfg_we = 1'b0;
        check(n == 54, "R2 latency", 32'(n), 54);
        check(out_sample == exp, req, 32'(out_sample), 32'(exp));
        if (mid && mb < 30) mc[mb] = mcf;
        @(posedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R2 one-cycle strobe", 32'(out_valid), 0);
        if (hold > 0) begin
            extra = 1'b0;
            repeat (60) begin
                @(posedge clk); @(negedge clk);
                if (out_valid) extra = 1'b1;
            end
            check(!extra, "R3 busy input ignored", 32'(extra), 0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);
        run_sample(24'h12_3456, 0, 0, 0, 0, "R1 pass-through");
        check(out_sample == 24'h12_3456, "R1 unchanged sample", 32'(out_sample), 32'h12_3456);
        run_sample(24'hF0_0001, 0, 0, 0, 0, "R1 pass-through negative");
    endtask

    task automatic t_single_band();
        do_reset();
        write_coef(5'd3, {HALF, QTR, MHLF, QTR});
        run_sample(24'h20_0000, 0, 0, 0, 0, "R4 band eq sample 1");
        run_sample(24'h00_0000, 0, 0, 0, 0, "R6 state carried, zero input");
        run_sample(24'hF0_0000, 0, 0, 0, 0, "R4 band eq negative");
        run_sample(24'h01_2345, 0, 0, 0, 0, "R6 state carried 3");
    endtask

    task automatic t_cascade();
        do_reset();
        write_coef(5'd2, {ONE, 32'h0, 32'h0, 32'h0});
        write_coef(5'd20, {HALF, QTR, QTR, 32'h0});
        write_coef(5'd26, {MHLF, 32'h0, MHLF, QTR});
        run_sample(24'h10_0000, 0, 0, 0, 0, "R5 cascade 1");
        run_sample(24'h08_0000, 0, 0, 0, 0, "R5 cascade 2");
        run_sample(24'hF8_0000, 0, 0, 0, 0, "R5 cascade 3");
    endtask

    task automatic t_saturation();
        do_reset();
        write_coef(5'd0, {ONE, 32'h0, 32'h0, 32'h0});
        run_sample(24'h60_0000, 0, 0, 0, 0, "R7 below limit");
        run_sample(24'h60_0000, 0, 0, 0, 0, "R7 positive saturation");
        check(out_sample == 24'h7F_FFFF, "R7 positive limit", 32'(out_sample), 32'h7F_FFFF);
        do_reset();
        write_coef(5'd0, {ONE, 32'h0, 32'h0, 32'h0});
        run_sample(24'hA0_0000, 0, 0, 0, 0, "R7 below limit negative");
        run_sample(24'hA0_0000, 0, 0, 0, 0, "R7 negative saturation");
        check(out_sample == 24'h80_0000, "R7 negative limit", 32'(out_sample), 32'h80_0000);
    endtask

    task automatic t_headroom();
        do_reset();
        write_coef(5'd0, {ONE, 32'h0, 32'h0, 32'h0});
        write_coef(5'd1, {MONE, 32'h0, 32'h0, 32'h0});
        run_sample(24'h60_0000, 0, 0, 0, 0, "R11 first sample");
        run_sample(24'h60_0000, 0, 0, 0, 0, "R11 no internal clipping");
        check(out_sample == 24'h60_0000, "R11 exact value", 32'(out_sample), 32'h60_0000);
    endtask

    task automatic t_field_order();
        do_reset();
        write_coef(5'd7, {32'h0, 32'h0, 32'h0, HALF});
        run_sample(24'h20_0000, 0, 0, 0, 0, "R8 a2 only field");
        run_sample(24'h10_0000, 0, 0, 0, 0, "R8 a2 only field 2");
        write_coef(5'd7, {32'h0, HALF, 32'h0, 32'h0});
        run_sample(24'h20_0000, 0, 0, 0, 0, "R8 idle write used");
        run_sample(24'h00_0000, 0, 0, 0, 0, "R8 b2 only field");
        run_sample(24'h00_0000, 0, 0, 0, 0, "R8 b2 only field 2");
    endtask

    task automatic t_busy_input();
        do_reset();
        write_coef(5'd4, {HALF, 32'h0, QTR, 32'h0});
        run_sample(24'h30_0000, 40, 0, 0, 0, "R3 held input ignored");
        run_sample(24'h00_1000, 0, 0, 0, 0, "R3 next sample unaffected");
    endtask

    task automatic t_hold_write();
        do_reset();
        write_coef(5'd26, {HALF, 32'h0, 32'h0, 32'h0});
        run_sample(24'h20_0000, 0, 1, 5'd26, {MONE, 32'h0, 32'h0, 32'h0},
                   "R9 mid-pass write not used");
        run_sample(24'h20_0000, 0, 0, 0, 0, "R9 write used next sample");
        run_sample(24'h00_0000, 0, 0, 0, 0, "R9 write used after");
    endtask

    task automatic t_unused_slots();
        do_reset();
        write_coef(5'd27, {ONE, ONE, MHLF, MHLF});
        write_coef(5'd29, {ONE, ONE, MHLF, MHLF});
        write_coef(5'd30, {ONE, ONE, MHLF, MHLF});
        write_coef(5'd31, {ONE, ONE, MHLF, MHLF});
        run_sample(24'h33_3333, 0, 0, 0, 0, "R10 unused slot 1");
        run_sample(24'h22_2222, 0, 0, 0, 0, "R10 unused slot 2");
        check(out_sample == 24'h22_2222, "R10 output unchanged", 32'(out_sample), 32'h22_2222);
    endtask

    initial begin
        t_reset();
        t_single_band();
        t_cascade();
        t_saturation();
        t_headroom();
        t_field_order();
        t_busy_input();
        t_hold_write();
        t_unused_slots();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule